// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Timebase

This block is a memory-mapped watchdog with a free-running timebase counter. It is reached over a plain 32-bit register bus made of an address, a write strobe with write data, and a read strobe with registered read data. Software arms the watchdog by setting two enable bits that sit in two different registers. Arming clears the timebase. While armed, an internal interval counter of `2^WDT_EXP` cycles runs. The first time the interval ends, a warning flag is set and the interrupt output goes high. If the interval ends a second time while the warning flag is still set, the block pulses its reset output for one cycle and sets a sticky reset-cause flag.

Both flags are write-one-to-clear. Clearing the warning flag is the "kick": it also restarts the interval. A build-time switch, `ALLOW_STOP`, decides whether software may disarm a running watchdog. When the switch is 0, a running watchdog ignores writes that would clear either enable.

The control sequencer has three named states. `ST_IDLE` means not armed. `ST_RUN` means armed and counting. `ST_BITE` is the single cycle in which the reset output is driven. The transitions are:
- arm (`ST_IDLE`→`ST_RUN`): both enables are set.
- second expiry (`ST_RUN`→`ST_BITE`): the interval ends while the warning flag is set.
- bite done (`ST_BITE`→`ST_RUN`): the cycle after the bite, if still armed.
- disarm (`ST_RUN` or `ST_BITE`→`ST_IDLE`): either enable is cleared.

Top module: `wdog_top`

## Requirements
- R1: After reset, both enables, both flags, the interrupt and the reset output are 0, and reads of the control words at 0x0 and 0x4 return 0.
- R2: The interval counter advances only while enable A (bit 0 of the word at 0x0) and enable B (bit 0 of the word at 0x4) are both 1. With only one of them set, no expiry ever occurs.
- R3: Bit 3 of the word at 0x0 reads back enable B. Writes to that bit are ignored.
- R4: The timebase, read at 0x8, increases by one on every clock whether or not the watchdog is armed. Writes to 0x8 do not change it.
- R5: The timebase is cleared at the same clock edge that arms the watchdog, so a read issued in the next cycle returns 0.
- R6: After 2^WDT_EXP armed cycles with the warning flag clear, the warning flag (bit 1 of the word at 0x0) becomes 1. The interrupt output is high exactly while that flag is 1.
- R7: When the interval ends while the warning flag is 1, the reset output is high for exactly one cycle. The reset-cause flag (bit 2 of the word at 0x0) becomes 1 and stays 1 until it is cleared.
- R8: Writing 1 to bit 1 at 0x0 clears the warning flag and restarts a full interval. Writing 1 to bit 2 clears the reset-cause flag. Writing 0 to either bit leaves it unchanged.
- R9: With ALLOW_STOP=1, clearing either enable stops the interval counter and returns it to 0. A later re-arm waits a full interval before the next expiry.
- R10: With ALLOW_STOP=0, once both enables are 1, writes of 0 to either enable have no effect. Bit 3 at 0x0 still reads 1 and the watchdog keeps expiring.
- R11: Read data appears in the cycle after the read strobe and holds until the next read. Unmapped word addresses read as 0.
- R12: If a write of 1 to the warning bit lands on the same edge as an interval expiry, the clear wins. The flag stays 0 and a new full interval begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rd_data_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | High while the warning flag is set |
| wdog_rst_o | output | 1 | One-cycle reset pulse on second expiry |

## Verification
The bench times the first expiry to the exact cycle. A counter that starts one edge late or early, or that keeps a stale count across a disarm, would raise the interrupt one cycle off or too soon after a re-arm. It also hits an expiry edge with a simultaneous kick. A design that lets the expiry win there would set the warning flag and head toward an unwanted reset. The locked build is driven with disarm writes, which a design without the lock would obey, leaving the interrupt silent. The reset pulse is checked for width and for the sticky cause flag: a level output, or a flag dropped after the pulse, would show in the samples taken one cycle apart.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // word indices (byte address / 4)
    localparam int IDX_CTRL_A = 0;
    localparam int IDX_CTRL_B = 1;
    localparam int IDX_TBASE  = 2;

    // bit positions in control word A
    localparam int BIT_EN_A   = 0;
    localparam int BIT_WARN   = 1;
    localparam int BIT_CAUSE  = 2;
    localparam int BIT_EN_B_M = 3;

    // bit position in control word B
    localparam int BIT_EN_B   = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_BITE = 2'd2
    } wdog_state_t;

endpackage

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
    parameter int TB_W = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            arm_i,
    output logic [TB_W-1:0] count_o
);

    logic [TB_W-1:0] tb_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    tb_q <= '0;
        else if (arm_i) tb_q <= '0;
        else            tb_q <= tb_q + TB_W'(1);
    end

    assign count_o = tb_q;

    assert_tb_incr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> (tb_q == $past(tb_q) + TB_W'(1)));

    assert_tb_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> (tb_q == '0));

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int WDT_EXP = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic warn_clr_i,
    input  logic cause_clr_i,
    output logic warn_o,
    output logic cause_o,
    output logic bite_o
);

    localparam logic [WDT_EXP-1:0] CNT_LAST = '1;

    wdog_state_t state_q, state_d;
    logic [WDT_EXP-1:0] cnt_q;
    logic warn_q, cause_q;
    logic expire;

    // interval end; a simultaneous kick takes precedence
    assign expire = run_i && (cnt_q == CNT_LAST) && !warn_clr_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_i) state_d = ST_RUN;
            ST_RUN: begin
                if (!run_i)                 state_d = ST_IDLE;
                else if (expire && warn_q)  state_d = ST_BITE;
            end
            ST_BITE: state_d = run_i ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            warn_q  <= 1'b0;
            cause_q <= 1'b0;
        end else begin
            if (!run_i || warn_clr_i) cnt_q <= '0;
            else                      cnt_q <= cnt_q + WDT_EXP'(1);

            if (warn_clr_i)  warn_q <= 1'b0;
            else if (expire) warn_q <= 1'b1;

            if (cause_clr_i)            cause_q <= 1'b0;
            else if (expire && warn_q)  cause_q <= 1'b1;
        end
    end

    always_comb begin
        warn_o  = warn_q;
        cause_o = cause_q;
        bite_o  = (state_q == ST_BITE);
    end

    assert_bite_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bite_o |=> !bite_o);

    assert_bite_after_warn_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bite_o) |-> $past(warn_q));

    assert_cause_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cause_q && !cause_clr_i) |=> cause_q);

    assert_idle_no_bite_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> !bite_o);

endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int TB_W       = 32,
    parameter bit ALLOW_STOP = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              warn_i,
    input  logic              cause_i,
    input  logic [TB_W-1:0]   tb_i,
    output logic              run_o,
    output logic              arm_o,
    output logic              warn_clr_o,
    output logic              cause_clr_o
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word;
    logic wr_a, wr_b, locked;
    logic en_a_q, en_b_q, en_a_d, en_b_d;
    logic [DATA_W-1:0] rd_q, rd_d;
    logic unused_bits;

    assign word        = addr_i[ADDR_W-1:2];
    assign unused_bits = ^{addr_i[1:0], wr_data_i[DATA_W-1:3]};
    assign wr_a        = wr_en_i && (word == IDX_W'(IDX_CTRL_A));
    assign wr_b        = wr_en_i && (word == IDX_W'(IDX_CTRL_B));

    generate
        if (ALLOW_STOP) begin : g_free
            assign locked = 1'b0;
        end else begin : g_lock
            assign locked = en_a_q && en_b_q;
            assert_lock_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (en_a_q && en_b_q) |=> (en_a_q && en_b_q));
        end
    endgenerate

    always_comb begin
        en_a_d = en_a_q;
        en_b_d = en_b_q;
        if (wr_a) en_a_d = locked ? 1'b1 : wr_data_i[BIT_EN_A];
        if (wr_b) en_b_d = locked ? 1'b1 : wr_data_i[BIT_EN_B];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_a_q <= 1'b0;
            en_b_q <= 1'b0;
        end else begin
            en_a_q <= en_a_d;
            en_b_q <= en_b_d;
        end
    end

    assign run_o       = en_a_q && en_b_q;
    assign arm_o       = !run_o && en_a_d && en_b_d;
    assign warn_clr_o  = wr_a && wr_data_i[BIT_WARN];
    assign cause_clr_o = wr_a && wr_data_i[BIT_CAUSE];

    always_comb begin
        rd_d = '0;
        if (word == IDX_W'(IDX_CTRL_A)) begin
            rd_d[BIT_EN_A]   = en_a_q;
            rd_d[BIT_WARN]   = warn_i;
            rd_d[BIT_CAUSE]  = cause_i;
            rd_d[BIT_EN_B_M] = en_b_q;
        end else if (word == IDX_W'(IDX_CTRL_B)) begin
            rd_d[BIT_EN_B]   = en_b_q;
        end else if (word == IDX_W'(IDX_TBASE)) begin
            rd_d[TB_W-1:0]   = tb_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_d;
    end

    assign rd_data_o = rd_q;

    assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int TB_W       = 32,
    parameter int WDT_EXP    = 16,
    parameter bit ALLOW_STOP = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o,
    output logic              wdog_rst_o
);

    logic run, arm, warn_clr, cause_clr, warn, cause, bite;
    logic [TB_W-1:0] tb_count;

    wdog_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TB_W(TB_W), .ALLOW_STOP(ALLOW_STOP)
    ) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
        .warn_i(warn), .cause_i(cause), .tb_i(tb_count), .run_o(run),
        .arm_o(arm), .warn_clr_o(warn_clr), .cause_clr_o(cause_clr)
    );

    wdog_timebase #(.TB_W(TB_W)) u_tbase (
        .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .count_o(tb_count)
    );

    wdog_fsm #(.WDT_EXP(WDT_EXP)) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .warn_clr_i(warn_clr),
        .cause_clr_i(cause_clr), .warn_o(warn), .cause_o(cause), .bite_o(bite)
    );

    assign irq_o      = warn;
    assign wdog_rst_o = bite;

    assert_irq_tracks_warn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == ADDR_W'(0) && wr_data_i[1]) |=> !irq_o);

endmodule

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;

    localparam int EXP = 5;
    localparam int P   = 1 << EXP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, sel = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_a, rd_l;
    logic        irq_a, rst_a, irq_l, rst_l;
    logic        rd_fl = 1'b0;
    int          checks = 0, fails = 0;

    always #4 clk = ~clk;

    wdog_top #(.WDT_EXP(EXP), .ALLOW_STOP(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en && !sel),
        .wr_data_i(wdata), .rd_en_i(rd_en && !sel), .rd_data_o(rd_a),
        .irq_o(irq_a), .wdog_rst_o(rst_a));

    wdog_top #(.WDT_EXP(EXP), .ALLOW_STOP(1'b0)) dut_lock_i (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en && sel),
        .wr_data_i(wdata), .rd_en_i(rd_en && sel), .rd_data_o(rd_l),
        .irq_o(irq_l), .wdog_rst_o(rst_l));

    typedef struct {
        logic [31:0] exp;
        bit          chk;
        bit          lockd;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all bus tasks are entered just after a falling edge
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.chk = 1'b1; it.lockd = sel; it.tag = tag;
        sb_q.push_back(it);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic bus_raw(input logic [3:0] a, output logic [31:0] v);
        rd_item_t it;
        it.exp = '0; it.chk = 1'b0; it.lockd = sel; it.tag = "raw";
        sb_q.push_back(it);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = sel ? rd_l : rd_a;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected read results as the design returns them
    always @(posedge clk) rd_fl <= rd_en;

    initial begin
        forever begin
            @(negedge clk);
            if (rd_fl && sb_q.size() > 0) begin
                rd_item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.lockd ? rd_l : rd_a;
                if (it.chk) check(act == it.exp, it.tag, act, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] t1, t2, t3, hold;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check(!irq_a && !rst_a, "R1 outputs after reset", {irq_a, rst_a}, 0);
        bus_read(4'h0, 32'h0, "R1 ctrl A after reset");
        bus_read(4'h4, 32'h0, "R1 ctrl B after reset");

        // R4 free-running, read-only timebase
        bus_raw(4'h8, t1);
        bus_raw(4'h8, t2);
        check(t2 - t1 == 1, "R4 timebase step", t2 - t1, 1);
        bus_write(4'h8, 32'hDEAD_0000);
        bus_raw(4'h8, t3);
        check(t3 - t1 == 3, "R4 timebase ignores write", t3 - t1, 3);

        // R2/R3 single enable does nothing, mirror bit
        bus_write(4'h4, 32'h1);
        bus_read(4'h0, 32'h8, "R3 enable B mirror");
        idle(2 * P + 5);
        check(!irq_a, "R2 enable B alone no expiry", irq_a, 0);
        bus_write(4'h4, 32'h0);
        bus_write(4'h0, 32'h8);
        bus_read(4'h0, 32'h0, "R3 mirror bit write ignored");
        bus_write(4'h0, 32'h1);
        idle(2 * P + 5);
        check(!irq_a, "R2 enable A alone no expiry", irq_a, 0);

        // arm at edge E
        bus_write(4'h4, 32'h1);
        bus_read(4'h8, 32'd0, "R5 timebase cleared on arm");
        bus_read(4'h8, 32'd1, "R5 timebase counts after arm");
        idle(P - 3);
        check(!irq_a, "R6 no irq one cycle early", irq_a, 0);
        idle(1);
        check(irq_a, "R6 irq at interval end", irq_a, 1);
        bus_read(4'h0, 32'hB, "R6 warn flag set");
        idle(P - 2);
        check(!rst_a, "R7 no reset one cycle early", rst_a, 0);
        idle(1);
        check(rst_a, "R7 reset pulse high", rst_a, 1);
        idle(1);
        check(!rst_a, "R7 reset pulse one cycle", rst_a, 0);
        bus_read(4'h0, 32'hF, "R7 cause flag sticky");

        // R8 kick and clear
        bus_write(4'h0, 32'h7);
        check(!irq_a, "R8 irq cleared by kick", irq_a, 0);
        bus_read(4'h0, 32'h9, "R8 both flags cleared");
        idle(P - 2);
        check(!irq_a, "R8 full interval after kick", irq_a, 0);
        idle(1);
        check(irq_a, "R8 expiry after kick", irq_a, 1);
        bus_write(4'h0, 32'h1);
        bus_read(4'h0, 32'hB, "R8 write zero keeps flag");

        // R12 kick coinciding with expiry
        bus_write(4'h0, 32'h3);
        idle(P - 1);
        bus_write(4'h0, 32'h3);
        check(!irq_a, "R12 kick wins over expiry", irq_a, 0);
        idle(P - 1);
        check(!irq_a, "R12 new interval not early", irq_a, 0);
        idle(1);
        check(irq_a, "R12 new interval ends", irq_a, 1);

        // R9 disarm and re-arm
        bus_write(4'h4, 32'h0);
        bus_read(4'h0, 32'h3, "R9 enable B cleared");
        bus_write(4'h0, 32'h3);
        idle(2 * P + 4);
        check(!irq_a && !rst_a, "R9 stopped no expiry", {irq_a, rst_a}, 0);
        bus_write(4'h4, 32'h1);
        idle(P - 1);
        check(!irq_a, "R9 re-arm full interval", irq_a, 0);
        idle(1);
        check(irq_a, "R9 expiry after re-arm", irq_a, 1);
        bus_write(4'h0, 32'h2);
        idle(2 * P);
        check(!irq_a && !rst_a, "R9 enable A clear stops", {irq_a, rst_a}, 0);
        bus_read(4'h0, 32'h8, "R9 enable A cleared");

        // R11 unmapped read and hold
        bus_read(4'hC, 32'h0, "R11 unmapped reads zero");
        bus_raw(4'h8, hold);
        idle(3);
        check(rd_a == hold, "R11 read data holds", rd_a, hold);

        // R10 locked build
        sel = 1'b1;
        bus_write(4'h0, 32'h1);
        bus_write(4'h4, 32'h1);
        bus_write(4'h4, 32'h0);
        bus_write(4'h0, 32'h0);
        bus_read(4'h0, 32'h9, "R10 locked enables stay set");
        bus_read(4'h4, 32'h1, "R10 locked enable B reads 1");
        idle(P - 5);
        check(!irq_l, "R10 locked not early", irq_l, 0);
        idle(1);
        check(irq_l, "R10 locked keeps running", irq_l, 1);

        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule